// File: doc/BRIEF.md
# Debug Mode Entry and Peripheral Halt Controller

This block keeps the debug-mode state of a small processor core. The core enters debug mode on a break-instruction strobe or on a falling edge of an active-low external break line. It leaves only on a return-from-debug strobe. While the core is in debug mode, the block blocks every maskable hardware interrupt and the non-maskable interrupt before they reach the core.

The block also drives clock enables for three groups of peripherals. Peripherals on the main peripheral clock, and peripherals on any other internal clock, each have a run bit. That bit chooses whether the group keeps running or halts while debug mode is active. Peripherals that take their clock from an external pin always stay enabled. A small register port writes the two run bits and reads them back. The same port reads a fixed start address for a 64-byte debug work area.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A one-cycle pulse on `brk_insn_i` outside debug mode sets `dbg_mode_o` at the next rising clock edge.
- R2: `brk_n_i` passes through a two-flop synchronizer. After the line falls, `dbg_mode_o` rises at the third rising edge. A line held low causes one entry only.
- R3: `dbg_mode_o` stays set until `retd_i` is seen in debug mode, and clears at that edge. A `retd_i` pulse outside debug mode has no effect.
- R4: While `dbg_mode_o` is 1, `irq_o` is all zeros and `nmi_o` is 0. Otherwise they follow `irq_i` and `nmi_i`.
- R5: The main-clock run bit is bit 0 of the config register and resets to 0. In debug mode, `pclk_en_o` is 0 when this bit is 0 and 1 when it is 1.
- R6: The other-clock run bit is bit 1 and resets to 0. In debug mode, `oclk_en_o` is 0 when this bit is 0 and 1 when it is 1.
- R7: When `cfg_we_i` is 1, `cfg_wdata_i[1:0]` is loaded at the clock edge. This works in or out of debug mode, and the enables follow from the next cycle.
- R8: `xclk_en_o` is 1 at all times.
- R9: With `rd_sel_i`=1, `rd_data_o` returns the work-area start address. That address is `WORK_BASE` rounded down to a 64-byte boundary. With `rd_sel_i`=0, it returns the run bits in bits [1:0] and zeros above them.
- R10: A break request (strobe or pin edge) that arrives while the core is already in debug mode is ignored. One `retd_i` then leaves debug mode, and the mode stays clear afterwards.
- R11: If `retd_i` and a break request fall in the same cycle in debug mode, `dbg_mode_o` clears for exactly one cycle and then sets again.
- R12: Outside debug mode, `pclk_en_o` and `oclk_en_o` are 1. After reset, `dbg_mode_o` is 0 and the run bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_insn_i | input | 1 | Break-instruction strobe |
| retd_i | input | 1 | Return-from-debug strobe |
| brk_n_i | input | 1 | External break line, active low, asynchronous |
| irq_i | input | IRQ_N | Hardware interrupt requests |
| nmi_i | input | 1 | Non-maskable interrupt request |
| cfg_we_i | input | 1 | Run-bit register write enable |
| cfg_wdata_i | input | 2 | Run bits: [0] main clock, [1] other clocks |
| rd_sel_i | input | 1 | Read select: 0 run bits, 1 work-area address |
| rd_data_o | output | ADDR_W | Read data |
| irq_o | output | IRQ_N | Interrupts passed to the core |
| nmi_o | output | 1 | NMI passed to the core |
| dbg_mode_o | output | 1 | Debug mode active |
| pclk_en_o | output | 1 | Main peripheral clock enable |
| oclk_en_o | output | 1 | Other internal peripheral clock enable |
| xclk_en_o | output | 1 | Externally clocked peripheral enable |

## Verification
Two things can land on the same edge: a return-from-debug strobe and a new break request. The bench provokes this by raising both strobes in one cycle while in debug mode. It passes only if the mode flag drops for exactly one cycle and then rises again. A second overlap is a run-bit write during debug mode. The bench judges it by the affected clock enable changing on the very next cycle, while the mode flag holds.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;

    typedef struct packed {
        logic run_other;
        logic run_main;
    } run_cfg_t;

    typedef struct packed {
        logic ext;
        logic other;
        logic main;
    } clk_en_t;

    localparam logic SEL_RUN  = 1'b0;
    localparam logic SEL_BASE = 1'b1;

    function automatic logic [31:0] align_down(input logic [31:0] addr, input int unsigned bytes);
        return addr & ~(bytes - 1);
    endfunction

endpackage

// File: rtl/dbg_brk_sync.sv
module dbg_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic brk_n_i,
    output logic fall_o
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], brk_n_i};
            prev <= sh[STAGES-1];
        end
    end

    assign fall_o = prev & ~sh[STAGES-1];

    // R2: a held-low line gives a single-cycle event
    a_r2_one_pulse: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);
endmodule

// File: rtl/dbg_state.sv
module dbg_state (
    input  logic clk,
    input  logic rst,
    input  logic brk_insn_i,
    input  logic brk_fall_i,
    input  logic retd_i,
    output logic mode_o
);
    logic mode_q;
    logic pend_q;
    logic req;

    assign req = brk_insn_i | brk_fall_i | pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= 1'b0;
            if (mode_q && retd_i) begin
                mode_q <= 1'b0;
                pend_q <= brk_insn_i | brk_fall_i;
            end else if (!mode_q && req) begin
                mode_q <= 1'b1;
            end
        end
    end

    assign mode_o = mode_q;

    a_r1_enter: assert property (@(posedge clk) disable iff (rst)
        (!mode_o && brk_insn_i) |=> mode_o);
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_o && !retd_i) |=> mode_o);
    a_r3_exit: assert property (@(posedge clk) disable iff (rst)
        (mode_o && retd_i) |=> !mode_o);
    a_r11_reenter: assert property (@(posedge clk) disable iff (rst)
        (mode_o && retd_i && brk_insn_i) |=> !mode_o ##1 mode_o);
endmodule

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
    import dbgctl_pkg::*;
#(
    parameter int              ADDR_W     = 24,
    parameter logic [31:0]     WORK_BASE  = 32'h0000_7FC0,
    parameter int unsigned     WORK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [1:0]        wdata_i,
    input  logic              rd_sel_i,
    output logic [ADDR_W-1:0] rdata_o,
    output run_cfg_t          run_o
);
    localparam logic [ADDR_W-1:0] BASE_AL = ADDR_W'(align_down(WORK_BASE, WORK_BYTES));

    run_cfg_t run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (we_i) run_q <= wdata_i;
    end

    always_comb begin
        if (rd_sel_i == SEL_BASE) rdata_o = BASE_AL;
        else                      rdata_o = {{(ADDR_W-2){1'b0}}, run_q};
    end

    assign run_o = run_q;

    a_r7_write: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (run_o == $past(wdata_i)));
    a_r9_base_aligned: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_i == SEL_BASE) |-> (rdata_o[5:0] == 6'd0));
endmodule

// File: rtl/dbg_halt_gate.sv
module dbg_halt_gate
    import dbgctl_pkg::*;
#(
    parameter int IRQ_N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  run_cfg_t         run_i,
    input  logic [IRQ_N-1:0] irq_i,
    input  logic             nmi_i,
    output logic [IRQ_N-1:0] irq_o,
    output logic             nmi_o,
    output clk_en_t          en_o
);
    assign irq_o    = mode_i ? '0 : irq_i;
    assign nmi_o    = nmi_i & ~mode_i;
    assign en_o.main  = ~mode_i | run_i.run_main;
    assign en_o.other = ~mode_i | run_i.run_other;
    assign en_o.ext   = 1'b1;

    a_r4_masked: assert property (@(posedge clk) disable iff (rst)
        mode_i |-> (irq_o == '0 && !nmi_o));
    a_r5_main_halt: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !run_i.run_main) |-> !en_o.main);
    a_r6_other_halt: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !run_i.run_other) |-> !en_o.other);
    a_r12_free_run: assert property (@(posedge clk) disable iff (rst)
        !mode_i |-> (en_o.main && en_o.other && irq_o == irq_i));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbgctl_pkg::*;
#(
    parameter int          IRQ_N      = 8,
    parameter int          ADDR_W     = 24,
    parameter int          SYNC_STG   = 2,
    parameter logic [31:0] WORK_BASE  = 32'h0000_7FC0,
    parameter int unsigned WORK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk_insn_i,
    input  logic              retd_i,
    input  logic              brk_n_i,
    input  logic [IRQ_N-1:0]  irq_i,
    input  logic              nmi_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_wdata_i,
    input  logic              rd_sel_i,
    output logic [ADDR_W-1:0] rd_data_o,
    output logic [IRQ_N-1:0]  irq_o,
    output logic              nmi_o,
    output logic              dbg_mode_o,
    output logic              pclk_en_o,
    output logic              oclk_en_o,
    output logic              xclk_en_o
);
    logic     brk_fall;
    logic     mode;
    run_cfg_t run;
    clk_en_t  en;

    dbg_brk_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .brk_n_i(brk_n_i), .fall_o(brk_fall)
    );

    dbg_state u_state (
        .clk(clk), .rst(rst), .brk_insn_i(brk_insn_i),
        .brk_fall_i(brk_fall), .retd_i(retd_i), .mode_o(mode)
    );

    dbg_cfg_regs #(.ADDR_W(ADDR_W), .WORK_BASE(WORK_BASE), .WORK_BYTES(WORK_BYTES)) u_cfg (
        .clk(clk), .rst(rst), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
        .rd_sel_i(rd_sel_i), .rdata_o(rd_data_o), .run_o(run)
    );

    dbg_halt_gate #(.IRQ_N(IRQ_N)) u_gate (
        .clk(clk), .rst(rst), .mode_i(mode), .run_i(run),
        .irq_i(irq_i), .nmi_i(nmi_i), .irq_o(irq_o), .nmi_o(nmi_o), .en_o(en)
    );

    assign dbg_mode_o = mode;
    assign pclk_en_o  = en.main;
    assign oclk_en_o  = en.other;
    assign xclk_en_o  = en.ext;

    a_r10_ignore_nested: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode_o && !retd_i && brk_insn_i) |=> dbg_mode_o);
endmodule

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        brk_insn_i = 1'b0, retd_i = 1'b0, brk_n_i = 1'b1;
    logic [7:0]  irq_i = 8'h00;
    logic        nmi_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_wdata_i = 2'b00;
    logic        rd_sel_i = 1'b0;
    logic [23:0] rd_data_o;
    logic [7:0]  irq_o;
    logic        nmi_o, dbg_mode_o, pclk_en_o, oclk_en_o, xclk_en_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dbg_halt_ctrl dut (
        .clk(clk), .rst(rst), .brk_insn_i(brk_insn_i), .retd_i(retd_i),
        .brk_n_i(brk_n_i), .irq_i(irq_i), .nmi_i(nmi_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o), .nmi_o(nmi_o),
        .dbg_mode_o(dbg_mode_o), .pclk_en_o(pclk_en_o),
        .oclk_en_o(oclk_en_o), .xclk_en_o(xclk_en_o)
    );

    // {wdata[1:0], enter, exp_main_en, exp_other_en}
    localparam logic [4:0] VEC [8] = '{
        5'b00_0_11, 5'b00_1_00, 5'b01_1_10, 5'b10_1_01,
        5'b11_1_11, 5'b11_0_11, 5'b01_0_11, 5'b10_0_11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse_brk();
        brk_insn_i = 1'b1; cyc(); brk_insn_i = 1'b0;
    endtask

    task automatic pulse_retd();
        retd_i = 1'b1; cyc(); retd_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(); cyc(); rst = 1'b0; cyc();
        // R12 reset state
        chk("R12 mode", dbg_mode_o, 0);
        chk("R12 pclk", pclk_en_o, 1);
        chk("R12 oclk", oclk_en_o, 1);
        rd_sel_i = 1'b0; #1;
        chk("R12 run bits", rd_data_o, 0);
        rd_sel_i = 1'b1; #1;
        chk("R9 base", rd_data_o, 24'h007FC0);
        rd_sel_i = 1'b0;

        // table of run-bit settings
        irq_i = 8'hA5; nmi_i = 1'b1;
        foreach (VEC[k]) begin
            cfg_we_i = 1'b1; cfg_wdata_i = VEC[k][4:3]; cyc(); cfg_we_i = 1'b0;
            #1 chk("R9 run readback", rd_data_o, {22'd0, VEC[k][4:3]});
            if (VEC[k][2]) pulse_brk();
            chk("R1 mode", dbg_mode_o, VEC[k][2]);
            chk("R5 pclk", pclk_en_o, VEC[k][1]);
            chk("R6 oclk", oclk_en_o, VEC[k][0]);
            chk("R8 xclk", xclk_en_o, 1);
            chk("R4 irq", irq_o, VEC[k][2] ? 8'h00 : 8'hA5);
            chk("R4 nmi", nmi_o, !VEC[k][2]);
            if (VEC[k][2]) begin
                pulse_retd();
                chk("R3 exit", dbg_mode_o, 0);
                chk("R12 free", {pclk_en_o, oclk_en_o}, 2'b11);
            end
        end

        // R7 write during debug
        cfg_we_i = 1'b1; cfg_wdata_i = 2'b00; cyc(); cfg_we_i = 1'b0;
        pulse_brk();
        chk("R7 halted", pclk_en_o, 0);
        cfg_we_i = 1'b1; cfg_wdata_i = 2'b01; cyc(); cfg_we_i = 1'b0;
        chk("R7 live", pclk_en_o, 1);
        chk("R7 other", oclk_en_o, 0);
        chk("R7 mode kept", dbg_mode_o, 1);

        // R10 nested break ignored
        pulse_brk();
        chk("R10 still", dbg_mode_o, 1);
        pulse_retd();
        chk("R10 exit", dbg_mode_o, 0);
        cyc(); cyc();
        chk("R10 stays out", dbg_mode_o, 0);

        // R3 retd outside debug
        pulse_retd();
        chk("R3 no effect", dbg_mode_o, 0);
        cyc();
        chk("R3 no effect 2", dbg_mode_o, 0);

        // R11 simultaneous retd and break
        pulse_brk();
        brk_insn_i = 1'b1; retd_i = 1'b1; cyc(); brk_insn_i = 1'b0; retd_i = 1'b0;
        chk("R11 drop", dbg_mode_o, 0);
        cyc();
        chk("R11 reenter", dbg_mode_o, 1);
        pulse_retd();
        cyc();
        chk("R11 out", dbg_mode_o, 0);

        // R2 pin entry timing and single entry
        brk_n_i = 1'b0; cyc();
        chk("R2 edge1", dbg_mode_o, 0);
        cyc();
        chk("R2 edge2", dbg_mode_o, 0);
        cyc();
        chk("R2 edge3", dbg_mode_o, 1);
        pulse_retd();
        for (int i = 0; i < 5; i++) cyc();
        chk("R2 held low once", dbg_mode_o, 0);
        brk_n_i = 1'b1;
        for (int i = 0; i < 4; i++) cyc();

        // R10 pin edge while in debug
        pulse_brk();
        brk_n_i = 1'b0;
        for (int i = 0; i < 4; i++) cyc();
        pulse_retd();
        chk("R10 pin exit", dbg_mode_o, 0);
        cyc(); cyc();
        chk("R10 pin ignored", dbg_mode_o, 0);
        brk_n_i = 1'b1;
        cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule